// File: doc/BRIEF.md
# Multi-Channel ADC Scan Controller with Automatic Power-Down

This block sequences conversions on a multi-channel analog-to-digital converter. A scan begins on a software start strobe or on a rising edge of one hardware source. That source is picked from a bank of timer outputs plus one external trigger pin, and it counts only while a hardware-enable input is high. Each scan converts every channel whose bit is set in a channel-enable mask, from the lowest index to the highest. The controller then returns to idle. Set and clear strobes write the mask, and each strobe touches only the bits it carries as one.

For each channel the controller sends one conversion request to the analog cell and waits for the cell's completion pulse. It stores the result in that channel's slot of the data output and raises that channel's bit of a transfer-request vector for one cycle, so a DMA engine can collect it. In sleep mode the cell is unpowered while idle. On a start the controller powers the cell, waits a programmable number of start-up cycles, and powers it down again once the scan ends. A start that arrives while a scan is running is dropped.

Top module: `adc_scan_ctrl`

## Requirements
- R1: A one-cycle `sw_start` pulse while idle begins a scan, whether `hw_trig_en` is low or high.
- R2: A hardware start occurs only while `hw_trig_en` is high, and only from the source chosen by `trig_sel`. Values 0 to NUM_TMR-1 select `tmr_out[trig_sel]` and the value NUM_TMR selects `ext_trig`. Edges on any other source have no effect.
- R3: A hardware start is taken on a rising edge of the selected source. Holding that source high afterwards starts no further scan.
- R4: On a clock edge, each one bit of `ch_set` sets the matching bit of `ch_en_mask` and each one bit of `ch_clr` clears it. Zero bits leave the mask unchanged, and the new mask is visible one cycle later.
- R5: A scan issues exactly one single-cycle `conv_start` per enabled channel, with `conv_ch` holding that channel's index. Channels go in ascending index order, and disabled channels are skipped.
- R6: When `conv_done` arrives, `conv_data` is stored in slot `conv_ch` of `ch_data` (bits `[ch*RES_W +: RES_W]`). Bit `ch` of `xfer_req` is high for one cycle in the next cycle, and at most one bit is high at a time.
- R7: With `sleep_en` high, `adc_pwr_on` is low while idle. It rises on an accepted start, the first `conv_start` follows exactly `startup_cycles`+2 cycles after it rises, and it is low again when `busy` falls. With `sleep_en` low, `adc_pwr_on` stays high.
- R8: Starts, software or hardware, that arrive while `busy` is high, including the start-up wait, are discarded and never queued.
- R9: A start with an all-zero mask keeps `busy` high for a single cycle, issues no conversion and no transfer request, and leaves the cell unpowered in sleep mode.
- R10: Under reset `busy`, `conv_start`, `xfer_req`, `adc_pwr_on` and `ch_en_mask` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_start | input | 1 | Software start strobe |
| hw_trig_en | input | 1 | Enables the selected hardware start source |
| trig_sel | input | SEL_W | Hardware source select: timers 0..NUM_TMR-1, external at NUM_TMR |
| tmr_out | input | NUM_TMR | Timer output levels |
| ext_trig | input | 1 | External trigger level |
| ch_set | input | NUM_CH | Mask set strobes, one bit per channel |
| ch_clr | input | NUM_CH | Mask clear strobes, one bit per channel |
| ch_en_mask | output | NUM_CH | Current channel-enable mask |
| sleep_en | input | 1 | Power the cell down between scans |
| startup_cycles | input | DLY_W | Start-up wait after power-up, in cycles |
| adc_pwr_on | output | 1 | Analog cell power enable |
| conv_start | output | 1 | Single-cycle conversion request to the cell |
| conv_ch | output | CH_W | Channel being converted |
| conv_done | input | 1 | Conversion complete pulse from the cell |
| conv_data | input | RES_W | Conversion result, valid with `conv_done` |
| ch_data | output | NUM_CH*RES_W | Latest result of each channel |
| xfer_req | output | NUM_CH | One-cycle transfer request for each channel |
| busy | output | 1 | High from an accepted start until the scan ends |

## Verification
The checks assume the analog cell behaves: it gives one `conv_done` pulse per `conv_start`, only while a conversion is outstanding, and never in the same cycle as the request. They also assume `sleep_en` and `startup_cycles` hold still during a scan, and that no channel is set and cleared in the same cycle. The testbench stub answers every request after a fixed latency with a value derived from the channel. The testbench writes the mask, the sleep setting and the start-up count only while the block is idle, and waits two cycles after each change before it starts a scan.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,   // waiting for a start
        SQ_WAKE = 2'd1,   // cell powered, counting start-up time
        SQ_SCAN = 2'd2,   // choosing the next channel
        SQ_WAIT = 2'd3    // conversion outstanding
    } seq_state_e;

endpackage

// File: rtl/scan_trig_detect.sv
module scan_trig_detect #(
    parameter int NUM_TMR = 3,
    localparam int NSRC   = NUM_TMR + 1,
    localparam int SEL_W  = $clog2(NSRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hw_trig_en,
    input  logic [SEL_W-1:0]   trig_sel,
    input  logic [NUM_TMR-1:0] tmr_out,
    input  logic               ext_trig,
    output logic               hit
);
    logic [NSRC-1:0] src;
    logic            lvl;
    logic            lvl_q;

    assign src = {ext_trig, tmr_out};

    always_comb begin
        lvl = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (trig_sel == SEL_W'(i)) lvl = src[i];
        end
    end

    // previous level follows the selected source at all times,
    // so a level held across a scan does not look like a new edge
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign hit = hw_trig_en & lvl & ~lvl_q;

endmodule

// File: rtl/scan_chan_mask.sv
module scan_chan_mask #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_set,
    input  logic [NUM_CH-1:0] ch_clr,
    output logic [NUM_CH-1:0] mask
);
    logic [NUM_CH-1:0] mask_d, mask_q;

    always_comb mask_d = (mask_q | ch_set) & ~ch_clr;

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask = mask_q;

endmodule

// File: rtl/scan_lsb_pick.sv
module scan_lsb_pick #(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] vec,
    output logic [CH_W-1:0]   idx,
    output logic              any
);
    // walk downward so the lowest set bit is written last
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = CH_W'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int NUM_TMR = 3,
    parameter int RES_W   = 10,
    parameter int DLY_W   = 8,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int SEL_W  = $clog2(NUM_TMR + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sw_start,
    input  logic                    hw_trig_en,
    input  logic [SEL_W-1:0]        trig_sel,
    input  logic [NUM_TMR-1:0]      tmr_out,
    input  logic                    ext_trig,
    input  logic [NUM_CH-1:0]       ch_set,
    input  logic [NUM_CH-1:0]       ch_clr,
    output logic [NUM_CH-1:0]       ch_en_mask,
    input  logic                    sleep_en,
    input  logic [DLY_W-1:0]        startup_cycles,
    output logic                    adc_pwr_on,
    output logic                    conv_start,
    output logic [CH_W-1:0]         conv_ch,
    input  logic                    conv_done,
    input  logic [RES_W-1:0]        conv_data,
    output logic [NUM_CH*RES_W-1:0] ch_data,
    output logic [NUM_CH-1:0]       xfer_req,
    output logic                    busy
);
    typedef struct packed {
        seq_state_e        st;
        logic [NUM_CH-1:0] scan;   // channels still to convert
        logic [CH_W-1:0]   cur;
        logic [DLY_W-1:0]  cnt;
        logic              pwr;
        logic              conv;
        logic [NUM_CH-1:0] xfer;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              hw_hit;
    logic              start;
    logic [NUM_CH-1:0] mask_q;
    logic [CH_W-1:0]   pick_idx;
    logic              pick_any;

    scan_trig_detect #(.NUM_TMR(NUM_TMR)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_trig_en (hw_trig_en),
        .trig_sel   (trig_sel),
        .tmr_out    (tmr_out),
        .ext_trig   (ext_trig),
        .hit        (hw_hit)
    );

    scan_chan_mask #(.NUM_CH(NUM_CH)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .ch_set (ch_set),
        .ch_clr (ch_clr),
        .mask   (mask_q)
    );

    scan_lsb_pick #(.NUM_CH(NUM_CH)) u_pick (
        .vec (ctl_q.scan),
        .idx (pick_idx),
        .any (pick_any)
    );

    assign start = sw_start | hw_hit;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.conv = 1'b0;
        ctl_d.xfer = '0;
        unique case (ctl_q.st)
            SQ_IDLE: begin
                if (start) begin
                    ctl_d.scan = mask_q;
                    if (sleep_en && (|mask_q)) begin
                        ctl_d.st  = SQ_WAKE;
                        ctl_d.cnt = startup_cycles;
                    end else begin
                        ctl_d.st  = SQ_SCAN;
                    end
                end
            end
            SQ_WAKE: begin
                if (ctl_q.cnt == '0) ctl_d.st  = SQ_SCAN;
                else                 ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
            SQ_SCAN: begin
                if (pick_any) begin
                    ctl_d.conv           = 1'b1;
                    ctl_d.cur            = pick_idx;
                    ctl_d.scan[pick_idx] = 1'b0;
                    ctl_d.st             = SQ_WAIT;
                end else begin
                    ctl_d.st = SQ_IDLE;
                end
            end
            SQ_WAIT: begin
                if (conv_done) begin
                    ctl_d.xfer[ctl_q.cur] = 1'b1;
                    ctl_d.st              = SQ_SCAN;
                end
            end
            default: ctl_d.st = SQ_IDLE;
        endcase
        ctl_d.pwr = ~sleep_en
                  | (ctl_d.st == SQ_WAKE)
                  | (ctl_d.st == SQ_WAIT)
                  | ((ctl_d.st == SQ_SCAN) && (|ctl_d.scan));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= SQ_IDLE;
        end else begin
            ctl_q      <= ctl_d;
        end
    end

    // per-channel result slots
    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        logic [RES_W-1:0] res_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                res_q <= '0;
            else if ((ctl_q.st == SQ_WAIT) && conv_done && (ctl_q.cur == CH_W'(g)))
                res_q <= conv_data;
        end
        assign ch_data[g*RES_W +: RES_W] = res_q;
    end

    assign ch_en_mask = mask_q;
    assign adc_pwr_on = ctl_q.pwr;
    assign conv_start = ctl_q.conv;
    assign conv_ch    = ctl_q.cur;
    assign xfer_req   = ctl_q.xfer;
    assign busy       = (ctl_q.st != SQ_IDLE);

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              conv_start,
    input logic              adc_pwr_on,
    input logic              sleep_en,
    input logic              conv_done,
    input logic [NUM_CH-1:0] xfer_req
);
    AST_XFER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(xfer_req)); // R6

    AST_XFER_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (|xfer_req) |-> $past(conv_done)); // R6

    AST_CONV_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> adc_pwr_on); // R7

    AST_CONV_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy); // R5

    AST_CONV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R5

    AST_SLEEP_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(sleep_en)) |-> !adc_pwr_on); // R7

endmodule

bind adc_scan_ctrl adc_scan_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .conv_start (conv_start),
    .adc_pwr_on (adc_pwr_on),
    .sleep_en   (sleep_en),
    .conv_done  (conv_done),
    .xfer_req   (xfer_req)
);

// File: tb/test_adc_scan_ctrl.sv
`timescale 1ns/1ps
module test_adc_scan_ctrl;
    localparam int NCH = 8;
    localparam int NTM = 3;
    localparam int RW  = 10;
    localparam int DW  = 8;
    localparam int CW  = $clog2(NCH);
    localparam int SW  = $clog2(NTM + 1);
    localparam int LAT = 3;
    localparam int NV  = 7;

    // {set, clr, sleep, startup, kind, sel}; kind 0 = sw start, 1 = sw start with hw enabled, 2 = hw edge
    localparam logic [28:0] VEC [NV] = '{
        {8'hA5, 8'h00, 1'b0, 8'd0,  2'd0, 2'd0},
        {8'h00, 8'h21, 1'b1, 8'd5,  2'd2, 2'd1},
        {8'h0F, 8'h80, 1'b1, 8'd0,  2'd1, 2'd2},
        {8'hF0, 8'h0F, 1'b0, 8'd0,  2'd2, 2'd3},
        {8'h01, 8'h00, 1'b1, 8'd12, 2'd2, 2'd0},
        {8'hFF, 8'h00, 1'b1, 8'd3,  2'd0, 2'd0},
        {8'h00, 8'h7E, 1'b0, 8'd0,  2'd2, 2'd2}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sw_start = 1'b0;
    logic              hw_trig_en = 1'b0;
    logic [SW-1:0]     trig_sel = '0;
    logic [NTM-1:0]    tmr_out = '0;
    logic              ext_trig = 1'b0;
    logic [NCH-1:0]    ch_set = '0;
    logic [NCH-1:0]    ch_clr = '0;
    logic [NCH-1:0]    ch_en_mask;
    logic              sleep_en = 1'b0;
    logic [DW-1:0]     startup_cycles = '0;
    logic              adc_pwr_on;
    logic              conv_start;
    logic [CW-1:0]     conv_ch;
    logic              conv_done;
    logic [RW-1:0]     conv_data;
    logic [NCH*RW-1:0] ch_data;
    logic [NCH-1:0]    xfer_req;
    logic              busy;

    int total = 0, errs = 0, cyc = 0;
    int xfer_n, conv_n, busy_n, last_ch, wake_dly, wake_cnt, ofs;
    bit counting, pwr_seen, pwr_prev;
    logic [NCH-1:0] model;

    always #5 clk = ~clk;

    adc_scan_ctrl #(.NUM_CH(NCH), .NUM_TMR(NTM), .RES_W(RW), .DLY_W(DW)) i_adc_scan_ctrl (
        .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .hw_trig_en(hw_trig_en),
        .trig_sel(trig_sel), .tmr_out(tmr_out), .ext_trig(ext_trig),
        .ch_set(ch_set), .ch_clr(ch_clr), .ch_en_mask(ch_en_mask),
        .sleep_en(sleep_en), .startup_cycles(startup_cycles), .adc_pwr_on(adc_pwr_on),
        .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
        .conv_data(conv_data), .ch_data(ch_data), .xfer_req(xfer_req), .busy(busy)
    );

    // fixed-latency analog cell stand-in
    int          lat = 0;
    logic [CW-1:0] ch_l = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            lat <= 0; conv_done <= 1'b0; conv_data <= '0;
        end else begin
            if (conv_start) begin
                lat <= LAT; ch_l <= conv_ch;
            end else if (lat != 0) begin
                lat <= lat - 1;
            end
            conv_done <= (lat == 1) && !conv_start;
            conv_data <= RW'(int'(ch_l) * 37 + ofs);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (conv_start) conv_n++;
            if (busy) busy_n++;
            if (adc_pwr_on) pwr_seen = 1'b1;
            if (adc_pwr_on && !pwr_prev) begin
                wake_cnt = 0; counting = 1'b1;
            end else if (counting) begin
                wake_cnt++;
                if (conv_start) begin wake_dly = wake_cnt; counting = 1'b0; end
            end
            pwr_prev = adc_pwr_on;
            for (int i = 0; i < NCH; i++) begin
                if (xfer_req[i]) begin
                    xfer_n++;
                    chk(i > last_ch, "R5 ascending order", i, last_ch + 1);
                    chk(ch_data[i*RW +: RW] == RW'(i * 37 + ofs), "R6 stored data",
                        int'(ch_data[i*RW +: RW]), i * 37 + ofs);
                    last_ch = i;
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, errs);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic clear_log();
        xfer_n = 0; conv_n = 0; busy_n = 0; last_ch = -1;
        wake_dly = -1; counting = 1'b0; pwr_seen = 1'b0;
    endtask

    task automatic sw_pulse();
        sw_start = 1'b1; step(1); sw_start = 1'b0;
    endtask

    task automatic drive_src(input int sel, input logic v);
        if (sel == NTM) ext_trig = v;
        else            tmr_out[sel] = v;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 3000) begin step(1); n++; end
        chk(!busy, "R5 scan completes", int'(busy), 0);
    endtask

    task automatic run_vec(input int v);
        logic [7:0] set_b, clr_b, dly;
        logic       sl;
        int         kind, sel, pc;
        string      rq;
        {set_b, clr_b, sl, dly} = VEC[v][28:4];
        kind = int'(VEC[v][3:2]);
        sel  = int'(VEC[v][1:0]);
        ofs  = v * 3;
        ch_set = set_b; step(1); ch_set = '0;
        ch_clr = clr_b; step(1); ch_clr = '0;
        sleep_en = sl; startup_cycles = dly;
        model = (model | set_b) & ~clr_b;
        pc = $countones(model);
        step(2);
        chk(ch_en_mask == model, "R4 mask set/clear", int'(ch_en_mask), int'(model));
        clear_log();
        rq = (kind == 2) ? "R2 hw start" : "R1 sw start";
        if (kind == 2) begin
            hw_trig_en = 1'b1; trig_sel = SW'(sel);
            drive_src(sel, 1'b1); step(1);
        end else begin
            hw_trig_en = (kind == 1); trig_sel = SW'(sel);
            sw_pulse();
        end
        chk(busy, rq, int'(busy), 1);
        wait_idle();
        chk(conv_n == pc, "R5 one conversion per enabled channel", conv_n, pc);
        chk(xfer_n == pc, "R6 one request per enabled channel", xfer_n, pc);
        chk(adc_pwr_on == !sl, "R7 power after scan", int'(adc_pwr_on), int'(!sl));
        if (sl && pc > 0)
            chk(wake_dly == int'(dly) + 2, "R7 start-up wait", wake_dly, int'(dly) + 2);
        if (kind == 2) begin
            step(4);
            chk(conv_n == pc && !busy, "R3 held level no restart", conv_n, pc);
            drive_src(sel, 1'b0);
        end
        hw_trig_en = 1'b0;
        step(1);
    endtask

    initial begin
        model = '0;
        clear_log();
        ofs = 0;
        step(3);
        chk(!busy && !conv_start && xfer_req == '0, "R10 reset outputs", int'({busy, conv_start}), 0);
        chk(!adc_pwr_on && ch_en_mask == '0, "R10 reset power and mask", int'(ch_en_mask), 0);
        rst_n = 1'b1;
        step(2);

        for (int v = 0; v < NV; v++) run_vec(v);

        // R2: disabled hardware path ignores an edge
        sleep_en = 1'b0; clear_log();
        hw_trig_en = 1'b0; trig_sel = SW'(2);
        tmr_out[2] = 1'b1; step(5);
        chk(busy_n == 0, "R2 hw disabled", busy_n, 0);
        tmr_out[2] = 1'b0; step(1);

        // R2: edge on an unselected timer ignored
        clear_log();
        hw_trig_en = 1'b1; trig_sel = SW'(0);
        tmr_out[2] = 1'b1; step(5);
        chk(busy_n == 0, "R2 unselected source", busy_n, 0);
        tmr_out[2] = 1'b0; hw_trig_en = 1'b0; step(1);

        // R8: starts during start-up wait and scan are dropped
        ofs = 50;
        ch_set = 8'hFF; step(1); ch_set = '0;
        sleep_en = 1'b1; startup_cycles = 8'd6; step(2);
        clear_log();
        sw_pulse(); step(3);
        sw_pulse();
        hw_trig_en = 1'b1; trig_sel = SW'(NTM); ext_trig = 1'b1; step(12);
        sw_pulse();
        wait_idle();
        chk(conv_n == 8, "R8 no queued conversions", conv_n, 8);
        chk(xfer_n == 8, "R8 no queued requests", xfer_n, 8);
        step(5);
        chk(conv_n == 8 && !busy, "R8 nothing after scan", conv_n, 8);
        ext_trig = 1'b0; hw_trig_en = 1'b0; step(1);

        // R9: empty mask
        ch_clr = 8'hFF; step(1); ch_clr = '0; step(2);
        clear_log();
        sw_pulse(); step(4);
        chk(busy_n == 1, "R9 busy one cycle", busy_n, 1);
        chk(conv_n == 0 && xfer_n == 0, "R9 no conversions", conv_n + xfer_n, 0);
        chk(!pwr_seen, "R9 cell stays off", int'(pwr_seen), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, errs);
        $finish;
    end

endmodule